// File: doc/BRIEF.md
# Oscillator Mode and Clock-Switch Controller

This block makes the clock-source and run-enable decisions for a small microcontroller. From a 4-bit oscillator-mode configuration field it works out whether the frequency-multiplying PLL may be used, which PLL control policy applies, how long the oscillator needs to start, and what the OSC2 pin does. It then drives a one-hot select for the primary, PLL-multiplied or secondary low-frequency clock, and a CPU run-enable. The analog oscillators, the PLL and the glitch-free clock mux lie outside this block. Everything here runs on one reference clock, with a synchronous active-high power-on reset.

The PLL is available only in the high-speed crystal and external-clock families. It is controlled either by a software register bit, which can change at run time, or by the configuration field itself. The configuration field is sampled only at power-on reset, or when the clock source comes back from the secondary oscillator to the primary. Whenever the PLL enable rises, a lock timer restarts, and the CPU stays halted until the timer expires. Software may move execution to the secondary oscillator once that oscillator is ready, but only if the active-low switch-enable configuration bit allowed it at reset.

Top module: `osc_mode_ctrl`

## Requirements
- R1: Mode codes on `mode_cfg` are: 0 LP crystal, 1 XT crystal, 2 HS crystal, 3 HS with configuration PLL, 4 HS with software PLL, 5 external clock, 6 external clock with I/O pin, 7 external clock with configuration PLL, 8 external clock with software PLL, 9 RC, 10–15 treated as external clock. Only codes 3, 4, 7 and 8 may ever select the PLL clock (`clk_sel` = 3'b010). All other codes stay on the primary clock (3'b001) regardless of `pll_sw_en`.
- R2: In software-PLL modes, every reset returns to the primary clock. A `pll_sw_en` level held high through reset is ignored until it has been seen low. After that, `pll_sw_en` = 1 enables the PLL, and `pll_sw_en` = 0 returns to the primary clock (idle cycle, then 3'b001 with `cpu_run` high).
- R3: The mode field is sampled at reset. While running, changes on `mode_cfg` have no effect on the select or the OSC2 function. The field is sampled again in the cycle the clock source leaves the secondary oscillator, so a newly configured PLL mode takes effect after that round trip.
- R4: The PLL clock is selected only after the effective PLL enable has stayed high for LOCK_CYC cycles. `cpu_run` is low while the enable is high and the lock is still pending. Every rising edge of the enable restarts the count.
- R5: `osc2_clkout` = 1 for codes 5 and 10–15. `osc2_gpio` = 1 for codes 6, 7 and 8. Both are 0 for the crystal and RC codes.
- R6: `swen_n` is sampled at reset. A value of 1, which an erased device gives, blocks every switch to the secondary clock. Changing the pin after reset has no effect.
- R7: A secondary request (`sec_req` = 1) is ignored while `sec_ready` = 0. When the switch is allowed and the oscillator is ready, `clk_sel` goes 001 → 000 → 100, reaching 3'b100 on the third clock. When `sec_req` falls, the select returns to the primary clock the same way.
- R8: After reset, `cpu_run` rises exactly EXT_START_CYC clocks after reset release for external-clock codes (5–8, 10–15), and XTAL_START_CYC clocks after release for codes 0–4 and 9.
- R9: `clk_sel` is always one-hot or zero. A change between two sources always passes through exactly one cycle of 3'b000.
- R10: `cpu_run` is high only when start-up is complete, `clk_sel` equals the intended source, and no PLL lock is pending. In particular, it is low during the idle cycle and in the cycle before it.
- R11: While reset is asserted, and in the first cycle after it, `clk_sel` = 3'b001 and `cpu_run` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mode_cfg | input | 4 | Oscillator-mode configuration field |
| swen_n | input | 1 | Active-low clock-switch enable configuration bit |
| pll_sw_en | input | 1 | Software PLL-enable register bit |
| sec_req | input | 1 | Software request to run from the secondary oscillator |
| sec_ready | input | 1 | Secondary oscillator ready |
| clk_sel | output | 3 | One-hot clock select: bit 0 primary, bit 1 PLL, bit 2 secondary |
| cpu_run | output | 1 | CPU run-enable |
| osc2_clkout | output | 1 | OSC2 drives the clock divided by 4 |
| osc2_gpio | output | 1 | OSC2 released as port A bit 6 |

## Verification
The bench resets the block in every mode family and tells them apart by three things: the start-up length, the OSC2 function, and whether toggling `pll_sw_en` can ever reach the PLL select. Software-PLL runs hold the enable high through reset, then clear it and set it. This separates the arming rule from a plain level follow, and timing the second rise shows the lock count restarting. Secondary switching is tried with the oscillator not ready, with the erased and the disabled switch bit, and with the bit changed after reset. A final run rewrites `mode_cfg` while running and then round-trips through the secondary clock, which shows that the field is ignored mid-run and sampled again on return.

// File: rtl/osc_mode_pkg.sv
package osc_mode_pkg;

    localparam int MODE_W = 4;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_NONE = 3'b000;
    localparam logic [SEL_W-1:0] SEL_PRI  = 3'b001;
    localparam logic [SEL_W-1:0] SEL_PLL  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_SEC  = 3'b100;

    typedef enum logic [1:0] {
        PLL_NONE = 2'd0,
        PLL_CFG  = 2'd1,
        PLL_SW   = 2'd2
    } pll_policy_e;

    typedef enum logic [1:0] {
        PIN_OSC    = 2'd0,
        PIN_CLKOUT = 2'd1,
        PIN_GPIO   = 2'd2
    } osc2_fn_e;

    typedef struct packed {
        logic        ext_clk;
        pll_policy_e policy;
        osc2_fn_e    osc2;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] code);
        mode_info_t r;
        r.ext_clk = 1'b0;
        r.policy  = PLL_NONE;
        r.osc2    = PIN_OSC;
        case (code)
            4'd0, 4'd1, 4'd2, 4'd9: begin
                r.ext_clk = 1'b0;
            end
            4'd3: r.policy = PLL_CFG;
            4'd4: r.policy = PLL_SW;
            4'd6: begin
                r.ext_clk = 1'b1;
                r.osc2    = PIN_GPIO;
            end
            4'd7: begin
                r.ext_clk = 1'b1;
                r.policy  = PLL_CFG;
                r.osc2    = PIN_GPIO;
            end
            4'd8: begin
                r.ext_clk = 1'b1;
                r.policy  = PLL_SW;
                r.osc2    = PIN_GPIO;
            end
            default: begin
                r.ext_clk = 1'b1;
                r.osc2    = PIN_CLKOUT;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/osc_cfg_store.sv
module osc_cfg_store
    import osc_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_cfg,
    input  logic              swen_n,
    input  logic              reload,
    output mode_info_t        info,
    output logic              sw_allowed
);
    logic [MODE_W-1:0] mode_q;
    logic              allow_q;

    // Field is captured at reset and on return from the secondary clock
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_cfg;
            allow_q <= ~swen_n;
        end else if (reload) begin
            mode_q  <= mode_cfg;
        end
    end

    assign info       = decode_mode(mode_q);
    assign sw_allowed = allow_q;
endmodule

// File: rtl/osc_startup.sv
module osc_startup #(
    parameter int EXT_START_CYC  = 24,
    parameter int XTAL_START_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    output logic done
);
    localparam int MAX_CYC = (EXT_START_CYC > XTAL_START_CYC) ? EXT_START_CYC : XTAL_START_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = ext_clk ? CW'(EXT_START_CYC) : CW'(XTAL_START_CYC);
    assign done  = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
    import osc_mode_pkg::*;
#(
    parameter int LOCK_CYC = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  pll_policy_e policy,
    input  logic        pll_sw_en,
    input  logic        sec_active,
    output logic        pll_eff,
    output logic        locked
);
    localparam int LW = $clog2(LOCK_CYC + 1);

    logic          armed_q;
    logic [LW-1:0] lock_q;
    logic          lock_full;

    // A software enable held through reset must be seen low first
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (!pll_sw_en) begin
            armed_q <= 1'b1;
        end
    end

    always_comb begin
        pll_eff = 1'b0;
        if (!sec_active) begin
            case (policy)
                PLL_CFG: pll_eff = 1'b1;
                PLL_SW:  pll_eff = armed_q & pll_sw_en;
                default: pll_eff = 1'b0;
            endcase
        end
    end

    assign lock_full = (lock_q == LW'(LOCK_CYC));

    // Counter clears whenever the enable is low, so every rise restarts it
    always_ff @(posedge clk) begin
        if (rst || !pll_eff) begin
            lock_q <= '0;
        end else if (!lock_full) begin
            lock_q <= lock_q + 1'b1;
        end
    end

    assign locked = pll_eff & lock_full;
endmodule

// File: rtl/osc_src_sel.sv
module osc_src_sel
    import osc_mode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             started,
    input  logic             sec_req,
    input  logic             sec_ready,
    input  logic             sw_allowed,
    input  logic             pll_eff,
    input  logic             locked,
    output logic [SEL_W-1:0] clk_sel,
    output logic             cpu_run,
    output logic             sec_active,
    output logic             reload
);
    logic             sec_q;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] target;
    logic             go_sec;

    assign go_sec = !sec_q && started && sec_req && sec_ready && sw_allowed;
    assign reload = sec_q && !sec_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= 1'b0;
        end else if (go_sec) begin
            sec_q <= 1'b1;
        end else if (reload) begin
            sec_q <= 1'b0;
        end
    end

    always_comb begin
        if (sec_q) begin
            target = SEL_SEC;
        end else if (locked) begin
            target = SEL_PLL;
        end else begin
            target = SEL_PRI;
        end
    end

    // Break before make: drop the old source for one cycle, then take the new one
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_PRI;
        end else if (sel_q == SEL_NONE) begin
            sel_q <= target;
        end else if (sel_q != target) begin
            sel_q <= SEL_NONE;
        end
    end

    assign clk_sel    = sel_q;
    assign sec_active = sec_q;
    assign cpu_run    = started && (sel_q == target) && !(pll_eff && !locked);
endmodule

// File: rtl/osc_mode_ctrl.sv
module osc_mode_ctrl
    import osc_mode_pkg::*;
#(
    parameter int EXT_START_CYC  = 24,
    parameter int XTAL_START_CYC = 1024,
    parameter int LOCK_CYC       = 2000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  mode_cfg,
    input  logic        swen_n,
    input  logic        pll_sw_en,
    input  logic        sec_req,
    input  logic        sec_ready,
    output logic [2:0]  clk_sel,
    output logic        cpu_run,
    output logic        osc2_clkout,
    output logic        osc2_gpio
);
    mode_info_t info;
    logic       sw_allowed;
    logic       reload;
    logic       started;
    logic       pll_eff;
    logic       locked;
    logic       sec_active;
    logic       pll_capable;

    osc_cfg_store u_cfg (
        .clk        (clk),
        .rst        (rst),
        .mode_cfg   (mode_cfg),
        .swen_n     (swen_n),
        .reload     (reload),
        .info       (info),
        .sw_allowed (sw_allowed)
    );

    osc_startup #(
        .EXT_START_CYC  (EXT_START_CYC),
        .XTAL_START_CYC (XTAL_START_CYC)
    ) u_start (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (info.ext_clk),
        .done    (started)
    );

    osc_pll_ctrl #(
        .LOCK_CYC (LOCK_CYC)
    ) u_pll (
        .clk        (clk),
        .rst        (rst),
        .policy     (info.policy),
        .pll_sw_en  (pll_sw_en),
        .sec_active (sec_active),
        .pll_eff    (pll_eff),
        .locked     (locked)
    );

    osc_src_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .started    (started),
        .sec_req    (sec_req),
        .sec_ready  (sec_ready),
        .sw_allowed (sw_allowed),
        .pll_eff    (pll_eff),
        .locked     (locked),
        .clk_sel    (clk_sel),
        .cpu_run    (cpu_run),
        .sec_active (sec_active),
        .reload     (reload)
    );

    assign pll_capable = (info.policy != PLL_NONE);
    assign osc2_clkout = (info.osc2 == PIN_CLKOUT);
    assign osc2_gpio   = (info.osc2 == PIN_GPIO);
endmodule

// File: rtl/osc_mode_ctrl_chk.sv
module osc_mode_ctrl_chk #(
    parameter int LOCK_CYC = 2000
) (
    input logic       clk,
    input logic       rst,
    input logic       swen_n,
    input logic [2:0] clk_sel,
    input logic       cpu_run,
    input logic       pll_eff,
    input logic       pll_capable
);
    logic        swen_seen;
    int unsigned eff_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            swen_seen <= swen_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pll_eff) begin
            eff_len <= 0;
        end else if (eff_len < LOCK_CYC + 4) begin
            eff_len <= eff_len + 1;
        end
    end

    assert_sel_onehot0_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clk_sel));

    assert_idle_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == 3'b000) |=> (clk_sel != 3'b000));

    assert_no_direct_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_sel != 3'b000) |=> (clk_sel == 3'b000 || clk_sel == $past(clk_sel)));

    assert_run_has_source_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_run |-> (clk_sel != 3'b000));

    assert_sec_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
        clk_sel[2] |-> !swen_seen);

    assert_pll_mode_only_R1: assert property (@(posedge clk) disable iff (rst)
        clk_sel[1] |-> pll_capable);

    assert_pll_after_lock_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_sel[1]) |-> (eff_len >= LOCK_CYC));

    assert_reset_state_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (clk_sel == 3'b001 && !cpu_run));
endmodule

bind osc_mode_ctrl osc_mode_ctrl_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .swen_n      (swen_n),
    .clk_sel     (clk_sel),
    .cpu_run     (cpu_run),
    .pll_eff     (pll_eff),
    .pll_capable (pll_capable)
);

// File: tb/osc_mode_ctrl_test.sv
module osc_mode_ctrl_test;
    localparam int EXT_S  = 5;
    localparam int XTAL_S = 9;
    localparam int LOCK   = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mode_cfg = 4'd5;
    logic       swen_n = 1'b1;
    logic       pll_sw_en = 1'b0;
    logic       sec_req = 1'b0;
    logic       sec_ready = 1'b0;
    logic [2:0] clk_sel;
    logic       cpu_run;
    logic       osc2_clkout;
    logic       osc2_gpio;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    osc_mode_ctrl #(
        .EXT_START_CYC  (EXT_S),
        .XTAL_START_CYC (XTAL_S),
        .LOCK_CYC       (LOCK)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .mode_cfg    (mode_cfg),
        .swen_n      (swen_n),
        .pll_sw_en   (pll_sw_en),
        .sec_req     (sec_req),
        .sec_ready   (sec_ready),
        .clk_sel     (clk_sel),
        .cpu_run     (cpu_run),
        .osc2_clkout (osc2_clkout),
        .osc2_gpio   (osc2_gpio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] m, input logic sw);
        @(negedge clk);
        rst = 1'b1;
        mode_cfg = m;
        swen_n = sw;
        step(2);
        check("R11 sel in reset", {29'd0, clk_sel}, 32'h1);
        check("R11 run in reset", {31'd0, cpu_run}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_reset_ec();
        sec_req = 1'b0; sec_ready = 1'b0; pll_sw_en = 1'b0;
        do_reset(4'd5, 1'b1);
        step(1);
        check("R11 sel after release", {29'd0, clk_sel}, 32'h1);
        step(3);
        check("R8 ext run before start-up", {31'd0, cpu_run}, 32'h0);
        step(1);
        check("R8 ext run at start-up", {31'd0, cpu_run}, 32'h1);
        check("R5 ext clkout", {31'd0, osc2_clkout}, 32'h1);
        check("R5 ext gpio", {31'd0, osc2_gpio}, 32'h0);
    endtask

    task automatic t_ecio_and_xtal();
        do_reset(4'd6, 1'b1);
        step(EXT_S);
        check("R5 ecio gpio", {31'd0, osc2_gpio}, 32'h1);
        check("R5 ecio clkout", {31'd0, osc2_clkout}, 32'h0);
        do_reset(4'd0, 1'b1);
        step(XTAL_S - 1);
        check("R8 xtal run before start-up", {31'd0, cpu_run}, 32'h0);
        step(1);
        check("R8 xtal run at start-up", {31'd0, cpu_run}, 32'h1);
        check("R5 xtal osc2 pin", {30'd0, osc2_clkout, osc2_gpio}, 32'h0);
    endtask

    task automatic t_no_pll_modes();
        pll_sw_en = 1'b0;
        do_reset(4'd1, 1'b1);
        step(3);
        pll_sw_en = 1'b1;
        step(30);
        check("R1 XT no pll sel", {29'd0, clk_sel}, 32'h1);
        check("R1 XT run", {31'd0, cpu_run}, 32'h1);
        pll_sw_en = 1'b0;
        do_reset(4'd9, 1'b1);
        step(3);
        pll_sw_en = 1'b1;
        step(30);
        check("R1 RC no pll sel", {29'd0, clk_sel}, 32'h1);
        pll_sw_en = 1'b0;
    endtask

    task automatic t_cfg_pll();
        pll_sw_en = 1'b0;
        do_reset(4'd7, 1'b1);
        step(LOCK);
        check("R4 cfg pll still primary at lock", {29'd0, clk_sel}, 32'h1);
        check("R10 run low before pll select", {31'd0, cpu_run}, 32'h0);
        step(1);
        check("R9 idle cycle", {29'd0, clk_sel}, 32'h0);
        check("R10 run low in idle", {31'd0, cpu_run}, 32'h0);
        step(1);
        check("R1 cfg pll selected", {29'd0, clk_sel}, 32'h2);
        check("R4 run after lock", {31'd0, cpu_run}, 32'h1);
    endtask

    task automatic t_sw_pll();
        pll_sw_en = 1'b1;
        do_reset(4'd8, 1'b1);
        step(20);
        check("R2 held enable ignored", {29'd0, clk_sel}, 32'h1);
        check("R2 run on primary", {31'd0, cpu_run}, 32'h1);
        pll_sw_en = 1'b0;
        step(1);
        pll_sw_en = 1'b1;
        step(LOCK - 1);
        check("R4 sw lock pending sel", {29'd0, clk_sel}, 32'h1);
        check("R4 sw lock pending run", {31'd0, cpu_run}, 32'h0);
        step(2);
        check("R9 sw idle", {29'd0, clk_sel}, 32'h0);
        step(1);
        check("R2 sw pll selected", {29'd0, clk_sel}, 32'h2);
        check("R2 sw pll run", {31'd0, cpu_run}, 32'h1);
        pll_sw_en = 1'b0;
        step(1);
        check("R9 sw off idle", {29'd0, clk_sel}, 32'h0);
        step(1);
        check("R2 sw off primary", {29'd0, clk_sel}, 32'h1);
        check("R2 sw off run", {31'd0, cpu_run}, 32'h1);
        pll_sw_en = 1'b1;
        step(LOCK - 1);
        check("R4 lock restarted sel", {29'd0, clk_sel}, 32'h1);
        check("R4 lock restarted run", {31'd0, cpu_run}, 32'h0);
        step(3);
        check("R4 relocked sel", {29'd0, clk_sel}, 32'h2);
        do_reset(4'd8, 1'b1);
        step(20);
        check("R2 reset returns primary", {29'd0, clk_sel}, 32'h1);
        pll_sw_en = 1'b0;
    endtask

    task automatic t_sec_switch();
        sec_req = 1'b0; sec_ready = 1'b0;
        do_reset(4'd5, 1'b0);
        step(EXT_S);
        sec_req = 1'b1;
        step(6);
        check("R7 not ready ignored", {29'd0, clk_sel}, 32'h1);
        check("R7 not ready run", {31'd0, cpu_run}, 32'h1);
        sec_ready = 1'b1;
        step(1);
        check("R10 run low before switch", {31'd0, cpu_run}, 32'h0);
        check("R9 old source kept", {29'd0, clk_sel}, 32'h1);
        step(1);
        check("R9 sec idle", {29'd0, clk_sel}, 32'h0);
        step(1);
        check("R7 secondary selected", {29'd0, clk_sel}, 32'h4);
        check("R7 secondary run", {31'd0, cpu_run}, 32'h1);
        sec_req = 1'b0;
        step(2);
        check("R9 return idle", {29'd0, clk_sel}, 32'h0);
        step(1);
        check("R7 back to primary", {29'd0, clk_sel}, 32'h1);
        check("R7 primary run", {31'd0, cpu_run}, 32'h1);
        sec_ready = 1'b0;
    endtask

    task automatic t_sec_blocked();
        do_reset(4'd15, 1'b1);
        step(EXT_S + 2);
        check("R5 erased clkout", {31'd0, osc2_clkout}, 32'h1);
        sec_req = 1'b1; sec_ready = 1'b1;
        step(10);
        check("R6 erased blocks switch", {29'd0, clk_sel}, 32'h1);
        sec_req = 1'b0;
        do_reset(4'd5, 1'b1);
        step(EXT_S);
        swen_n = 1'b0;
        sec_req = 1'b1;
        step(10);
        check("R6 late enable ignored", {29'd0, clk_sel}, 32'h1);
        check("R6 run kept", {31'd0, cpu_run}, 32'h1);
        sec_req = 1'b0; sec_ready = 1'b0;
    endtask

    task automatic t_cfg_reload();
        pll_sw_en = 1'b0;
        do_reset(4'd5, 1'b0);
        step(EXT_S);
        mode_cfg = 4'd7;
        step(10);
        check("R3 mid-run sel unchanged", {29'd0, clk_sel}, 32'h1);
        check("R3 mid-run osc2 unchanged", {30'd0, osc2_clkout, osc2_gpio}, 32'h2);
        sec_req = 1'b1; sec_ready = 1'b1;
        step(3);
        check("R3 round trip on secondary", {29'd0, clk_sel}, 32'h4);
        sec_req = 1'b0;
        step(3);
        check("R3 reloaded primary", {29'd0, clk_sel}, 32'h1);
        check("R3 reloaded run pending", {31'd0, cpu_run}, 32'h0);
        check("R3 reloaded osc2", {30'd0, osc2_clkout, osc2_gpio}, 32'h1);
        step(7);
        check("R3 reloaded pll selected", {29'd0, clk_sel}, 32'h2);
        check("R3 reloaded run", {31'd0, cpu_run}, 32'h1);
        sec_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_ec();
        t_ecio_and_xtal();
        t_no_pll_modes();
        t_cfg_pll();
        t_sw_pll();
        t_sec_switch();
        t_sec_blocked();
        t_cfg_reload();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule